// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block runs the exception control path of a small core that has two stack pointers (main and process) and two execution modes (thread and handler). When an interrupt request is accepted it saves an eight-word register frame to memory and fetches the handler address from a vector table. It then marks the exception active, drops the pending mark, enters handler mode and hands the core a new PC. It also hands the core a special return code for the link register. The frame words are R0, R1, R2, R3, R12, LR, the return PC and the status word.

The block watches PC writes from the core. In handler mode, a write whose upper 28 bits are all ones is treated as a return request. A valid code starts the return sequence. Bit 3 of the code picks the mode to resume and bit 2 picks the stack to pop the frame from. The popped frame is then handed back to the register file. The memory port is a single-word port with a fixed read latency of one cycle and no stall. Priority arbitration, nesting and tail-chaining are left to the surrounding core.

Top module: `exc_seq_core`

## Requirements
- R1: In idle with no exception active, `irq_req` high at a clock edge starts entry. `pending` reads 1 from the next cycle until the entry commit cycle, where it reads 0. An `irq_req` that arrives while `active` is 1 is ignored: no memory access, and `pending` stays 0.
- R2: Stacking is 8 consecutive write cycles starting the cycle after acceptance. Write k (k = 0..7) goes to address SP-4*(k+1) and carries frame word 7-k. Frame word i is `frame_in[32*i +: 32]`, with 0=R0, 1=R1, 2=R2, 3=R3, 4=R12, 5=LR, 6=return PC and 7=status.
- R3: Entry uses the process stack pointer when the core was in thread mode with `spsel`=1, and the main stack pointer otherwise. That pointer is 32 lower after entry, and the other pointer is unchanged.
- R4: The cycle after the last stacking write issues one read at `VEC_BASE + 4*irq_num`. Two cycles later `pc_load` pulses for one cycle with `pc_value` equal to the word read.
- R5: In that same commit cycle: `lr_load` pulses, `active`=1, `pending`=0, `handler_mode`=1 and `spsel`=0. `lr_value` is 0xFFFFFFF1 if the core was interrupted in handler mode, 0xFFFFFFFD if it was in thread mode with `spsel`=1, and 0xFFFFFFF9 if it was in thread mode with `spsel`=0.
- R6: In idle and handler mode, a PC write of 0xFFFFFFF1, 0xFFFFFFF9 or 0xFFFFFFFD starts return. From the next cycle there are 8 consecutive reads, read k at SP+4k. The SP used is the process pointer if code bit 2 is 1 and the main pointer otherwise.
- R7: Two cycles after the last read, `frame_load` and `pc_load` pulse together. `frame_out` then holds the popped words in the R2 layout and `pc_value` holds word 6. The popped pointer is 32 higher, `handler_mode` equals NOT code bit 3, `spsel` equals code bit 2 and `active` is 0.
- R8: In idle and handler mode, a PC write with the upper 28 bits all ones that is none of the three valid codes pulses `ret_fault` for one cycle on the next cycle. It causes no memory access and leaves mode, stack select, active and both pointers unchanged.
- R9: A PC write in thread mode, or one whose upper 28 bits are not all ones, has no effect: no fault, no memory access and no state change.
- R10: While a sequence is running, `irq_req`, PC writes and stack-select writes are ignored. The running sequence completes unchanged and no new sequence follows it.
- R11: A write through `spsel_wr_en` in idle and thread mode sets `spsel` on the next cycle. In handler mode the write is ignored.
- R12: After reset: thread mode, `spsel`=0, `active`=0, `pending`=0, no memory request, no pulses, `msp_val`=`MSP_INIT` and `psp_val`=`PSP_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request to enter |
| irq_num | input | NUM_W | Exception number of the request |
| frame_in | input | 256 | Register snapshot to stack |
| pc_wr_en | input | 1 | Core writes the PC this cycle |
| pc_wr_data | input | 32 | Value written to the PC |
| spsel_wr_en | input | 1 | Write to the stack-select control bit |
| spsel_wr_data | input | 1 | New stack-select value |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| pc_load | output | 1 | Load `pc_value` into the PC |
| pc_value | output | 32 | New PC |
| lr_load | output | 1 | Load `lr_value` into the LR |
| lr_value | output | 32 | Return code for the LR |
| frame_load | output | 1 | Restore `frame_out` to the register file |
| frame_out | output | 256 | Popped register frame |
| handler_mode | output | 1 | 1 in handler mode |
| spsel | output | 1 | Stack-select control bit |
| pending | output | 1 | Accepted request not yet entered |
| active | output | 1 | Exception being handled |
| ret_fault | output | 1 | Reserved return code seen |
| msp_val | output | 32 | Main stack pointer |
| psp_val | output | 32 | Process stack pointer |

## Verification
The assertions assume that the core asserts at most one of `irq_req`, `pc_wr_en` and `spsel_wr_en` in a cycle. They also assume that the memory returns read data exactly one cycle after the read, with no stall. The stimulus drives each request for a single cycle at the falling edge and uses the bench memory model with that fixed latency. It starts return sequences only while an exception is active, so the stack pointers stay within the modelled memory. Stimulus that hits a busy sequence is applied on purpose, and only to check that it is ignored.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int unsigned XLEN        = 32;
    localparam int unsigned FRAME_WORDS = 8;
    localparam int unsigned FRAME_BITS  = FRAME_WORDS * XLEN;
    localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);
    localparam int unsigned FRAME_BYTES = FRAME_WORDS * 4;
    localparam int unsigned SLOT_PC     = 6;

    localparam logic [XLEN-1:0] RET_HND_MAIN = 32'hFFFF_FFF1;
    localparam logic [XLEN-1:0] RET_THR_MAIN = 32'hFFFF_FFF9;
    localparam logic [XLEN-1:0] RET_THR_PROC = 32'hFFFF_FFFD;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PUSH,
        SEQ_VEC,
        SEQ_VWAIT,
        SEQ_POP,
        SEQ_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic cand;
        logic valid;
        logic to_thread;
        logic use_psp;
    } ret_info_t;

    typedef struct packed {
        logic handler;
        logic spsel;
        logic active;
        logic pending;
    } mode_t;

    function automatic logic [XLEN-1:0] entry_code(input logic in_handler, input logic sel);
        if (in_handler)
            return RET_HND_MAIN;
        else if (sel)
            return RET_THR_PROC;
        else
            return RET_THR_MAIN;
    endfunction

    function automatic ret_info_t decode_ret(input logic [XLEN-1:0] v);
        ret_info_t r;
        r.cand      = &v[XLEN-1:4];
        r.valid     = (v == RET_HND_MAIN) || (v == RET_THR_MAIN) || (v == RET_THR_PROC);
        r.to_thread = v[3];
        r.use_psp   = v[2];
        return r;
    endfunction

endpackage

// File: rtl/exc_ret_decode.sv
module exc_ret_decode
    import exc_seq_pkg::*;
(
    input  logic [XLEN-1:0] pc_val,
    output ret_info_t       info
);
    always_comb info = decode_ret(pc_val);
endmodule

// File: rtl/exc_sp_bank.sv
module exc_sp_bank
    import exc_seq_pkg::*;
#(
    parameter logic [XLEN-1:0] MAIN_INIT = 32'h0000_0800,
    parameter logic [XLEN-1:0] PROC_INIT = 32'h0000_0C00
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_proc,
    input  logic            dec_en,
    input  logic            inc_en,
    output logic [XLEN-1:0] main_sp,
    output logic [XLEN-1:0] proc_sp
);
    localparam logic [XLEN-1:0] STEP = XLEN'(FRAME_BYTES);

    for (genvar g = 0; g < 2; g++) begin : g_sp
        localparam logic [XLEN-1:0] INIT = (g == 0) ? MAIN_INIT : PROC_INIT;
        logic            hit;
        logic [XLEN-1:0] val_q;
        assign hit = (sel_proc == 1'(g));
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= INIT;
            else if (hit && dec_en)
                val_q <= val_q - STEP;
            else if (hit && inc_en)
                val_q <= val_q + STEP;
        end
    end

    assign main_sp = g_sp[0].val_q;
    assign proc_sp = g_sp[1].val_q;
endmodule

// File: rtl/exc_frame_buf.sv
module exc_frame_buf
    import exc_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_en,
    input  logic [FRAME_BITS-1:0] cap_data,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [XLEN-1:0]       wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [XLEN-1:0]       rd_word,
    output logic [FRAME_BITS-1:0] frame_q
);
    for (genvar w = 0; w < FRAME_WORDS; w++) begin : g_word
        logic [XLEN-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (cap_en)
                word_q <= cap_data[w*XLEN +: XLEN];
            else if (wr_en && (wr_idx == IDX_W'(w)))
                word_q <= wr_data;
        end
        assign frame_q[w*XLEN +: XLEN] = word_q;
    end

    assign rd_word = frame_q[{rd_idx, 5'b0} +: XLEN];
endmodule

// File: rtl/exc_seq_core.sv
module exc_seq_core
    import exc_seq_pkg::*;
#(
    parameter int unsigned     NUM_W    = 6,
    parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_0000,
    parameter logic [XLEN-1:0] MSP_INIT = 32'h0000_0800,
    parameter logic [XLEN-1:0] PSP_INIT = 32'h0000_0C00
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  irq_req,
    input  logic [NUM_W-1:0]      irq_num,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  pc_wr_en,
    input  logic [XLEN-1:0]       pc_wr_data,
    input  logic                  spsel_wr_en,
    input  logic                  spsel_wr_data,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [XLEN-1:0]       mem_addr,
    output logic [XLEN-1:0]       mem_wdata,
    input  logic [XLEN-1:0]       mem_rdata,
    output logic                  pc_load,
    output logic [XLEN-1:0]       pc_value,
    output logic                  lr_load,
    output logic [XLEN-1:0]       lr_value,
    output logic                  frame_load,
    output logic [FRAME_BITS-1:0] frame_out,
    output logic                  handler_mode,
    output logic                  spsel,
    output logic                  pending,
    output logic                  active,
    output logic                  ret_fault,
    output logic [XLEN-1:0]       msp_val,
    output logic [XLEN-1:0]       psp_val
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    seq_state_e         state_q;
    mode_t              mode_q;
    logic [IDX_W-1:0]   cnt_q;
    logic               use_psp_q;
    logic [XLEN-1:0]    base_q;
    logic [XLEN-1:0]    code_q;
    logic [NUM_W-1:0]   num_q;
    logic               pc_load_q, lr_load_q, frame_load_q, fault_q;
    logic [XLEN-1:0]    pc_q, lr_q;

    ret_info_t          ret;
    logic               accept_irq;
    logic               ent_psp;
    logic [XLEN-1:0]    msp_w, psp_w;
    logic [XLEN-1:0]    rd_word;
    logic [FRAME_BITS-1:0] frame_w;
    logic               fb_wr_en;
    logic [IDX_W-1:0]   fb_wr_idx;
    logic [IDX_W-1:0]   fb_rd_idx;
    logic               sp_dec, sp_inc;
    logic [XLEN-1:0]    cnt_ext;
    logic [XLEN-1:0]    push_addr, pop_addr, vec_addr;

    exc_ret_decode u_dec (
        .pc_val (pc_wr_data),
        .info   (ret)
    );

    assign accept_irq = (state_q == SEQ_IDLE) && irq_req && !mode_q.active;
    assign ent_psp    = !mode_q.handler && mode_q.spsel;

    assign sp_dec = (state_q == SEQ_PUSH) && (cnt_q == LAST_IDX);
    assign sp_inc = (state_q == SEQ_DRAIN);

    exc_sp_bank #(
        .MAIN_INIT (MSP_INIT),
        .PROC_INIT (PSP_INIT)
    ) u_sp (
        .clk      (clk),
        .rst      (rst),
        .sel_proc (use_psp_q),
        .dec_en   (sp_dec),
        .inc_en   (sp_inc),
        .main_sp  (msp_w),
        .proc_sp  (psp_w)
    );

    always_comb begin
        fb_wr_en  = 1'b0;
        fb_wr_idx = cnt_q - 1'b1;
        if (state_q == SEQ_POP && cnt_q != '0)
            fb_wr_en = 1'b1;
        else if (state_q == SEQ_DRAIN) begin
            fb_wr_en  = 1'b1;
            fb_wr_idx = LAST_IDX;
        end
    end

    assign fb_rd_idx = LAST_IDX - cnt_q;

    exc_frame_buf u_frame (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (accept_irq),
        .cap_data (frame_in),
        .wr_en    (fb_wr_en),
        .wr_idx   (fb_wr_idx),
        .wr_data  (mem_rdata),
        .rd_idx   (fb_rd_idx),
        .rd_word  (rd_word),
        .frame_q  (frame_w)
    );

    assign cnt_ext   = XLEN'(cnt_q);
    assign push_addr = base_q - ((cnt_ext + 32'd1) << 2);
    assign pop_addr  = base_q + (cnt_ext << 2);
    assign vec_addr  = VEC_BASE + (XLEN'(num_q) << 2);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            SEQ_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = rd_word;
            end
            SEQ_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            SEQ_POP: begin
                mem_req  = 1'b1;
                mem_addr = pop_addr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SEQ_IDLE;
            mode_q       <= '0;
            cnt_q        <= '0;
            use_psp_q    <= 1'b0;
            base_q       <= '0;
            code_q       <= '0;
            num_q        <= '0;
            pc_load_q    <= 1'b0;
            lr_load_q    <= 1'b0;
            frame_load_q <= 1'b0;
            fault_q      <= 1'b0;
            pc_q         <= '0;
            lr_q         <= '0;
        end else begin
            pc_load_q    <= 1'b0;
            lr_load_q    <= 1'b0;
            frame_load_q <= 1'b0;
            fault_q      <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept_irq) begin
                        state_q        <= SEQ_PUSH;
                        cnt_q          <= '0;
                        mode_q.pending <= 1'b1;
                        use_psp_q      <= ent_psp;
                        base_q         <= ent_psp ? psp_w : msp_w;
                        code_q         <= entry_code(mode_q.handler, mode_q.spsel);
                        num_q          <= irq_num;
                    end else if (pc_wr_en && mode_q.handler && ret.cand) begin
                        if (ret.valid) begin
                            state_q   <= SEQ_POP;
                            cnt_q     <= '0;
                            use_psp_q <= ret.use_psp;
                            base_q    <= ret.use_psp ? psp_w : msp_w;
                            code_q    <= pc_wr_data;
                        end else begin
                            fault_q <= 1'b1;
                        end
                    end else if (spsel_wr_en && !mode_q.handler) begin
                        mode_q.spsel <= spsel_wr_data;
                    end
                end
                SEQ_PUSH: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_IDX)
                        state_q <= SEQ_VEC;
                end
                SEQ_VEC: state_q <= SEQ_VWAIT;
                SEQ_VWAIT: begin
                    pc_load_q      <= 1'b1;
                    pc_q           <= mem_rdata;
                    lr_load_q      <= 1'b1;
                    lr_q           <= code_q;
                    mode_q.active  <= 1'b1;
                    mode_q.pending <= 1'b0;
                    mode_q.handler <= 1'b1;
                    mode_q.spsel   <= 1'b0;
                    state_q        <= SEQ_IDLE;
                end
                SEQ_POP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_IDX)
                        state_q <= SEQ_DRAIN;
                end
                SEQ_DRAIN: begin
                    frame_load_q   <= 1'b1;
                    pc_load_q      <= 1'b1;
                    pc_q           <= frame_w[SLOT_PC*XLEN +: XLEN];
                    mode_q.handler <= !code_q[3];
                    mode_q.spsel   <= code_q[2];
                    mode_q.active  <= 1'b0;
                    state_q        <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign pc_load      = pc_load_q;
    assign pc_value     = pc_q;
    assign lr_load      = lr_load_q;
    assign lr_value     = lr_q;
    assign frame_load   = frame_load_q;
    assign frame_out    = frame_w;
    assign handler_mode = mode_q.handler;
    assign spsel        = mode_q.spsel;
    assign pending      = mode_q.pending;
    assign active       = mode_q.active;
    assign ret_fault    = fault_q;
    assign msp_val      = msp_w;
    assign psp_val      = psp_w;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
    import exc_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic            pc_load,
    input logic            lr_load,
    input logic [XLEN-1:0] lr_value,
    input logic            frame_load,
    input logic            handler_mode,
    input logic            spsel,
    input logic            pending,
    input logic            active,
    input logic            ret_fault,
    input logic [XLEN-1:0] msp_val,
    input logic [XLEN-1:0] psp_val
);
    AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && $past(mem_req && mem_we)) |-> (mem_addr == $past(mem_addr) - 32'd4)); // R2

    AST_POP_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && $past(mem_req && !mem_we)) |-> (mem_addr == $past(mem_addr) + 32'd4)); // R6

    AST_MSP_STEP: assert property (@(posedge clk) disable iff (rst)
        (msp_val != $past(msp_val)) |-> (msp_val == $past(msp_val) - 32'd32 || msp_val == $past(msp_val) + 32'd32)); // R3

    AST_PSP_STEP: assert property (@(posedge clk) disable iff (rst)
        (psp_val != $past(psp_val)) |-> (psp_val == $past(psp_val) - 32'd32 || psp_val == $past(psp_val) + 32'd32)); // R3

    AST_ENTRY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        lr_load |-> (pc_load && active && !pending && handler_mode && !spsel)); // R5

    AST_LR_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        lr_load |-> (lr_value == RET_HND_MAIN || lr_value == RET_THR_MAIN || lr_value == RET_THR_PROC)); // R5

    AST_HANDLER_MAIN_STACK: assert property (@(posedge clk) disable iff (rst)
        handler_mode |-> !spsel); // R11

    AST_RESTORE_PAIR: assert property (@(posedge clk) disable iff (rst)
        frame_load |-> (pc_load && !active && !lr_load)); // R7

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        ret_fault |-> (!mem_req && !pc_load && handler_mode == $past(handler_mode) && active == $past(active))); // R8

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ret_fault, lr_load, frame_load})); // R10

    AST_ACTIVE_IN_HANDLER: assert property (@(posedge clk) disable iff (rst)
        active |-> handler_mode); // R5
endmodule

bind exc_seq_core exc_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .pc_load      (pc_load),
    .lr_load      (lr_load),
    .lr_value     (lr_value),
    .frame_load   (frame_load),
    .handler_mode (handler_mode),
    .spsel        (spsel),
    .pending      (pending),
    .active       (active),
    .ret_fault    (ret_fault),
    .msp_val      (msp_val),
    .psp_val      (psp_val)
);

// File: tb/exc_seq_core_tb.sv
module exc_seq_core_tb_top;
    localparam int          NUM_W    = 6;
    localparam logic [31:0] VEC_BASE = 32'h0000_0000;
    localparam logic [31:0] MSP_INIT = 32'h0000_0800;
    localparam logic [31:0] PSP_INIT = 32'h0000_0C00;
    localparam logic [31:0] C_F1 = 32'hFFFF_FFF1;
    localparam logic [31:0] C_F9 = 32'hFFFF_FFF9;
    localparam logic [31:0] C_FD = 32'hFFFF_FFFD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_req = 1'b0;
    logic [NUM_W-1:0] irq_num = '0;
    logic [255:0] frame_in = '0;
    logic pc_wr_en = 1'b0;
    logic [31:0] pc_wr_data = '0;
    logic spsel_wr_en = 1'b0;
    logic spsel_wr_data = 1'b0;
    logic mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic pc_load, lr_load, frame_load;
    logic [31:0] pc_value, lr_value;
    logic [255:0] frame_out;
    logic handler_mode, spsel, pending, active, ret_fault;
    logic [31:0] msp_val, psp_val;

    always #5 clk = ~clk;

    exc_seq_core #(
        .NUM_W(NUM_W), .VEC_BASE(VEC_BASE), .MSP_INIT(MSP_INIT), .PSP_INIT(PSP_INIT)
    ) dut_i (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_num(irq_num), .frame_in(frame_in),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
        .spsel_wr_en(spsel_wr_en), .spsel_wr_data(spsel_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_value(pc_value),
        .lr_load(lr_load), .lr_value(lr_value), .frame_load(frame_load), .frame_out(frame_out),
        .handler_mode(handler_mode), .spsel(spsel), .pending(pending), .active(active),
        .ret_fault(ret_fault), .msp_val(msp_val), .psp_val(psp_val)
    );

    logic [31:0] mem [1024];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit m_handler, m_spsel, m_active;
    logic [31:0] m_msp, m_psp, m_lr;

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_code(input bit h, input bit s);
        return h ? C_F1 : (s ? C_FD : C_F9);
    endfunction

    task automatic chk_state(input string req);
        chk(handler_mode == m_handler && spsel == m_spsel && active == m_active,
            req, {handler_mode, spsel, active}, {m_handler, m_spsel, m_active});
        chk(msp_val == m_msp && psp_val == m_psp, req, {msp_val, psp_val}, {m_msp, m_psp});
    endtask

    task automatic do_entry(input logic [NUM_W-1:0] n, input bit poke);
        logic [255:0] fr;
        logic [31:0] sp0, code, vec;
        bit up;
        for (int i = 0; i < 8; i++) fr[i*32 +: 32] = $urandom;
        up = !m_handler && m_spsel;
        sp0 = up ? m_psp : m_msp;
        code = exp_code(m_handler, m_spsel);
        @(negedge clk);
        irq_req = 1'b1; irq_num = n; frame_in = fr;
        @(negedge clk);
        irq_req = 1'b0;
        chk(pending == 1'b1, "R1 pending after accept", pending, 1);
        for (int k = 0; k < 8; k++) begin
            chk(mem_req && mem_we && mem_addr == sp0 - 32'(4*(k+1)), "R2/R3 push address",
                {mem_req, mem_we, mem_addr}, {2'b11, sp0 - 32'(4*(k+1))});
            chk(mem_wdata == fr[(7-k)*32 +: 32], "R2 push word order", mem_wdata, fr[(7-k)*32 +: 32]);
            if (poke && k == 2) begin
                pc_wr_en = 1'b1; pc_wr_data = C_F9; irq_req = 1'b1;
                spsel_wr_en = 1'b1; spsel_wr_data = 1'b1;
            end else begin
                pc_wr_en = 1'b0; irq_req = 1'b0; spsel_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        pc_wr_en = 1'b0; irq_req = 1'b0; spsel_wr_en = 1'b0;
        chk(mem_req && !mem_we && mem_addr == VEC_BASE + 32'(n) * 4, "R4 vector read",
            mem_addr, VEC_BASE + 32'(n) * 4);
        @(negedge clk);
        vec = mem[(VEC_BASE[11:2] + 10'(n))];
        chk(!mem_req && !pc_load, "R4 wait cycle", {mem_req, pc_load}, 0);
        @(negedge clk);
        if (up) m_psp = m_psp - 32; else m_msp = m_msp - 32;
        m_handler = 1; m_spsel = 0; m_active = 1; m_lr = code;
        chk(pc_load && pc_value == vec, "R4 handler address", pc_value, vec);
        chk(lr_load && lr_value == code, "R5 return code", lr_value, code);
        chk(!pending, "R1 pending cleared at entry", pending, 0);
        chk_state("R5/R3 entry state");
        @(negedge clk);
        chk(!mem_req && !pc_load && !ret_fault, "R10 nothing after sequence", {mem_req, pc_load, ret_fault}, 0);
    endtask

    task automatic do_return(input logic [31:0] code);
        logic [255:0] ex;
        logic [31:0] sp0;
        bit up;
        up = code[2];
        sp0 = up ? m_psp : m_msp;
        for (int i = 0; i < 8; i++) ex[i*32 +: 32] = mem[10'((sp0 + 32'(4*i)) >> 2)];
        @(negedge clk);
        pc_wr_en = 1'b1; pc_wr_data = code;
        @(negedge clk);
        pc_wr_en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk(mem_req && !mem_we && mem_addr == sp0 + 32'(4*k), "R6 pop address",
                {mem_req, mem_we, mem_addr}, {2'b10, sp0 + 32'(4*k)});
            @(negedge clk);
        end
        chk(!mem_req, "R6 drain cycle", mem_req, 0);
        @(negedge clk);
        if (up) m_psp = m_psp + 32; else m_msp = m_msp + 32;
        m_handler = !code[3]; m_spsel = code[2]; m_active = 0;
        chk(frame_load && frame_out == ex, "R7 frame restore", frame_out, ex);
        chk(pc_load && pc_value == ex[6*32 +: 32], "R7 return PC", pc_value, ex[6*32 +: 32]);
        chk_state("R7 return state");
    endtask

    task automatic do_pcwrite(input logic [31:0] v, input bit expect_fault, input string req);
        @(negedge clk);
        pc_wr_en = 1'b1; pc_wr_data = v;
        @(negedge clk);
        pc_wr_en = 1'b0;
        chk(ret_fault == expect_fault && !mem_req, req, {ret_fault, mem_req}, {expect_fault, 1'b0});
        chk_state(req);
        @(negedge clk);
        chk(!ret_fault && !mem_req, req, {ret_fault, mem_req}, 0);
    endtask

    task automatic do_spsel(input bit v);
        @(negedge clk);
        spsel_wr_en = 1'b1; spsel_wr_data = v;
        @(negedge clk);
        spsel_wr_en = 1'b0;
        if (!m_handler) m_spsel = v;
        chk_state("R11 stack select write");
    endtask

    task automatic do_irq_active();
        @(negedge clk);
        irq_req = 1'b1; irq_num = 6'd3;
        @(negedge clk);
        irq_req = 1'b0;
        chk(!mem_req && !pending, "R1 request ignored while active", {mem_req, pending}, 0);
        chk_state("R1 state kept");
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int op;
        void'($urandom(32'd5150));
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        m_handler = 0; m_spsel = 0; m_active = 0; m_msp = MSP_INIT; m_psp = PSP_INIT; m_lr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!handler_mode && !spsel && !active && !pending && !mem_req && !pc_load && !lr_load
            && !frame_load && !ret_fault, "R12 reset outputs", 0, 0);
        chk_state("R12 reset pointers");

        // directed corners
        do_pcwrite(C_F9, 0, "R9 code in thread mode ignored");
        do_entry(6'd5, 0);
        do_spsel(1);
        do_irq_active();
        do_pcwrite(32'hFFFF_FFF0, 1, "R8 reserved code");
        do_pcwrite(32'hFFFF_FFF5, 1, "R8 reserved code");
        do_pcwrite(32'h1234_5679, 0, "R9 plain PC write");
        do_return(m_lr);
        do_spsel(1);
        do_entry(6'd63, 1);
        do_return(m_lr);
        do_entry(6'd0, 0);
        do_return(C_F1);
        do_entry(6'd7, 0);
        do_return(C_F9);

        // constrained random
        for (int it = 0; it < 400; it++) begin
            op = int'($urandom_range(0, 5));
            if (!m_active && (op <= 1)) do_entry(NUM_W'($urandom), ($urandom_range(0, 7) == 0));
            else if (m_active && op <= 1) begin
                v = ($urandom_range(0, 7) == 0) ? (($urandom_range(0, 1) == 1) ? C_F1 : C_F9) : m_lr;
                do_return(v);
            end else if (op == 2) begin
                v = {28'hFFFFFFF, 4'($urandom)};
                if (!m_handler)
                    do_pcwrite(v, 0, "R9 thread mode code ignored");
                else if (v != C_F1 && v != C_F9 && v != C_FD)
                    do_pcwrite(v, 1, "R8 reserved code fault");
            end else if (op == 3) do_spsel(1'($urandom));
            else if (op == 4 && m_active) do_irq_active();
            else do_pcwrite($urandom & 32'h7FFF_FFFF, 0, "R9 ordinary write");
        end
        if (m_active) do_return(m_lr);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule